// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block drives one pulse-width-modulated output from a single 32-bit control word. A programmable prescaler stretches the source clock into duty ticks, each lasting the prescale value plus one source cycles. An 8-bit period counter counts those ticks, so every output period is 256 ticks long. The output is high while the period counter is below the programmed duty value. A dedicated bit forces the output high for the whole period, and an enable bit gates the whole channel.

Software writes the control word through a strobe and can read it back at any time. A write takes effect at the next clock edge. It restarts the prescaler and the period counter, so any period in progress is abandoned. Clearing the enable bit drops the output at once and holds both counters at zero.

Top module: `pwm_prescaled_chan`

## Requirements
- R1: While reset is asserted and after it is released, the control word reads as zero and the output is low.
- R2: The control word layout is: prescale value in bits [12:0], duty value in bits [23:16], force-full bit 24, enable bit 31. Read-back returns the last written value with bits [30:25] and [15:13] read as zero.
- R3: Each duty tick lasts prescale+1 source clock cycles; a prescale value of 0 gives one tick per cycle.
- R4: A period is 256 duty ticks, so rising edges of the output are 256*(prescale+1) cycles apart, and the output is high for the first duty*(prescale+1) cycles of each period.
- R5: With the force-full bit set and the channel enabled, the output stays high in every cycle whatever the duty value.
- R6: With the enable bit clear, the output is low, beginning in the cycle after the write that clears the bit.
- R7: Any write restarts both counters from zero at the write's clock edge, so the new setting governs the output from the next cycle without finishing the old period.
- R8: While disabled, both counters are held at zero; enabling with a nonzero duty starts a fresh period with the output high in the first cycle.
- R9: With the duty value 0 and the force-full bit clear, the output stays low through every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Control word read-back |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The bench builds the block with its default widths: a 13-bit prescale field and an 8-bit duty field, so periods are the full 256 ticks. It programs small prescale values (0 to 3), which keeps a full period within about a thousand cycles and lets the bench time whole periods, high phases, mid-period rewrites and disable-while-high exactly. The all-ones write reaches every field's top bit, including the largest prescale value, for the read-back and masking checks.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SCALE_LSB = 0;
  localparam int unsigned DUTY_LSB  = 16;
  localparam int unsigned FULL_BIT  = 24;
  localparam int unsigned EN_BIT    = 31;

  // bits that hold state; the rest read as zero
  function automatic logic [WORD_W-1:0] ctrl_mask(int unsigned scale_w, int unsigned duty_w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(scale_w); i++) m[SCALE_LSB+i] = 1'b1;
    for (int i = 0; i < int'(duty_w); i++)  m[DUTY_LSB+i]  = 1'b1;
    m[FULL_BIT] = 1'b1;
    m[EN_BIT]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_chan_pkg::*;
#(
  parameter int unsigned SCALE_W = 13,
  parameter int unsigned DUTY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] cfg_o
);
  localparam logic [WORD_W-1:0] MASK = ctrl_mask(SCALE_W, DUTY_W);

  logic [WORD_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_data_i & MASK;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int unsigned SCALE_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [SCALE_W-1:0] cnt_o,
  output logic               tick_o
);
  logic [SCALE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  output logic [DUTY_W-1:0] cnt_o
);
  logic [DUTY_W-1:0] cnt_q;

  // wraps after 2**DUTY_W ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              en_i,
  input  logic              full_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] pos_i,
  output logic              pwm_o
);
  assign pwm_o = en_i & (full_i | (pos_i < duty_i));
endmodule

// File: rtl/pwm_prescaled_chan.sv
module pwm_prescaled_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned SCALE_W = 13,
  parameter int unsigned DUTY_W  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  logic [WORD_W-1:0]  cfg;
  logic               en, full, clr, tick;
  logic [SCALE_W-1:0] scale, div_cnt;
  logic [DUTY_W-1:0]  duty, per_cnt;

  pwm_ctrl_reg #(.SCALE_W(SCALE_W), .DUTY_W(DUTY_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .cfg_o(cfg)
  );

  assign en    = cfg[EN_BIT];
  assign full  = cfg[FULL_BIT];
  assign duty  = cfg[DUTY_LSB +: DUTY_W];
  assign scale = cfg[SCALE_LSB +: SCALE_W];
  // a write or a disabled channel restarts the period
  assign clr   = wr_en_i | ~en;

  pwm_tick_div #(.SCALE_W(SCALE_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clr), .scale_i(scale),
    .cnt_o(div_cnt), .tick_o(tick)
  );

  pwm_period_cnt #(.DUTY_W(DUTY_W)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clr), .tick_i(tick),
    .cnt_o(per_cnt)
  );

  pwm_cmp #(.DUTY_W(DUTY_W)) u_cmp (
    .en_i(en), .full_i(full), .duty_i(duty), .pos_i(per_cnt), .pwm_o(pwm_o)
  );

  assign rd_data_o = cfg;
endmodule

// File: rtl/pwm_prescaled_chan_chk.sv
module pwm_prescaled_chan_chk
  import pwm_chan_pkg::*;
#(
  parameter int unsigned SCALE_W = 13,
  parameter int unsigned DUTY_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [31:0]        wr_data_i,
  input logic [31:0]        rd_data_o,
  input logic               pwm_o,
  input logic [SCALE_W-1:0] div_q,
  input logic [DUTY_W-1:0]  per_q
);
  localparam logic [31:0] MASK = ctrl_mask(SCALE_W, DUTY_W);

  logic               en_w, full_w;
  logic [SCALE_W-1:0] scale_w;
  logic [DUTY_W-1:0]  duty_w;
  assign en_w    = rd_data_o[EN_BIT];
  assign full_w  = rd_data_o[FULL_BIT];
  assign scale_w = rd_data_o[SCALE_LSB +: SCALE_W];
  assign duty_w  = rd_data_o[DUTY_LSB +: DUTY_W];

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & MASK));

  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~MASK) == 32'h0);

  a_r3_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= scale_w);

  a_r4_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !wr_en_i && div_q == scale_w) |=> per_q == DUTY_W'($past(per_q) + 1'b1));

  a_r5_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && full_w) |-> pwm_o);

  a_r6_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |-> !pwm_o);

  a_r7_write_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (div_q == '0 && per_q == '0));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |-> (div_q == '0 && per_q == '0));

  a_r9_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && !full_w && duty_w == '0) |-> !pwm_o);
endmodule

bind pwm_prescaled_chan pwm_prescaled_chan_chk #(.SCALE_W(SCALE_W), .DUTY_W(DUTY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .pwm_o(pwm_o), .div_q(div_cnt), .per_q(per_cnt)
);

// File: tb/pwm_prescaled_chan_bench.sv
module pwm_prescaled_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_prescaled_chan u_pwm_prescaled_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pwm_o(pwm)
  );

  // reference model
  int unsigned m_cfg = 0, m_div = 0, m_per = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_div = 0; m_per = 0;
    end else if (wr_en) begin
      m_cfg = wr_data & 32'h81FF_1FFF; m_div = 0; m_per = 0;
    end else if (m_cfg[31] == 1'b0) begin
      m_div = 0; m_per = 0;
    end else if (m_div == (m_cfg & 32'h1FFF)) begin
      m_div = 0; m_per = (m_per + 1) % 256;
    end else begin
      m_div = m_div + 1;
    end
  end

  function automatic bit m_pwm();
    return m_cfg[31] && (m_cfg[24] || m_per < ((m_cfg >> 16) & 32'hFF));
  endfunction

  function automatic string m_tag();
    if (!m_cfg[31]) return "R6";
    if (m_cfg[24]) return "R5";
    if (((m_cfg >> 16) & 32'hFF) == 0) return "R9";
    return "R4";
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({m_tag(), " model pwm"}, pwm, m_pwm());
      chk("R2 model readback", rd_data, m_cfg);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic count_high(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (pwm) n++; else break;
    end
  endtask

  task automatic period_len(output int idx);
    bit prev;
    @(negedge clk); prev = pwm; idx = 0;
    forever begin
      @(negedge clk); idx++;
      if (pwm && !prev) break;
      prev = pwm;
    end
  endtask

  task automatic count_low_window(int n, bit lvl, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm == lvl) hits++;
    end
  endtask

  initial begin
    int n;
    idle(3);
    @(negedge clk);
    chk("R1 reset readback", rd_data, 0);
    chk("R1 reset pwm", pwm, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset pwm", pwm, 0);

    // R2: masking of all-ones and of unused-only bits
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 all ones readback", rd_data, 32'h81FF_1FFF);
    chk("R5 full with duty ff", pwm, 1);
    wr(32'h7E00_E000);
    @(negedge clk);
    chk("R2 unused bits read zero", rd_data, 0);

    // R4: scale 0, duty 64
    wr(32'h8040_0000);
    count_high(n);
    chk("R4 high cycles duty 64", n, 64);
    wr(32'h8040_0000);
    period_len(n);
    chk("R4 period scale 0", n, 256);
    chk("R3 scale 0 one tick per cycle", n, 256 * 1);

    // R3: scale 2, duty 3
    wr(32'h8003_0002);
    count_high(n);
    chk("R3 high cycles scale 2 duty 3", n, 9);
    wr(32'h8003_0002);
    period_len(n);
    chk("R3 period scale 2", n, 768);

    // R9: duty 0
    wr(32'h8000_0001);
    count_low_window(600, 1'b1, n);
    chk("R9 duty 0 never high", n, 0);

    // R5: full bit with duty 0
    wr(32'h8100_0000);
    count_low_window(600, 1'b1, n);
    chk("R5 full always high", n, 600);

    // R6: disable while high
    wr(32'h80FF_0000);
    idle(10);
    wr(32'h00FF_0000);
    @(negedge clk);
    chk("R6 low right after disable", pwm, 0);
    count_low_window(300, 1'b1, n);
    chk("R6 stays low while disabled", n, 0);

    // R8: enable from idle starts fresh period
    wr(32'h0010_0003);
    idle(7);
    wr(32'h8010_0003);
    count_high(n);
    chk("R8 fresh period high cycles", n, 64);

    // R7: rewrite in high phase, then in low phase
    wr(32'h8080_0001);
    idle(100);
    wr(32'h8004_0001);
    count_high(n);
    chk("R7 rewrite mid high", n, 8);
    wr(32'h8004_0000);
    idle(50);
    wr(32'h8004_0000);
    count_high(n);
    chk("R7 rewrite mid low restarts", n, 4);

    idle(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule